// File: doc/BRIEF.md
# Strobed Byte-Wide Configuration and Routing Port

This block sits behind a narrow 8-bit configuration port. The host drives one byte at a time. Bit 7 is a strobe, and a byte takes effect only on the clock cycle where bit 7 goes from 0 to 1. Bit 6 marks the kind of byte. When it is set, the low six bits name one of 64 registers, each 6 bits wide, and that register becomes the current one. When it is clear, the low six bits are a value for the register named by the most recent address byte. Each address allows one value write. The contents of the current register are returned on a 7-bit readback field. To read a register, the host strobes its address alone.

Registers 0 to 3 form a routing command. Register 0 holds the upper six bits of a 12-bit destination index and register 1 the lower six. Register 2 holds the upper six bits of a 12-bit source index and register 3 the lower six. A value write to register 3 stores the source in the routing table entry for that destination. Each destination holds exactly one source. One source may be stored for any number of destinations. Any routing entry can be read at any time through a separate select input.

Top module: `cfg_route_port`

## Requirements
- R1: While rst_n is low at a rising clock edge, all 64 registers, the current register number and every routing entry are cleared to 0, and no register is armed for a write. After reset, rd_value reads 0 and route_src reads 0 for every destination.
- R2: A byte acts only in the cycle where cfg_byte[7] is 1 and it was 0 in the previous cycle. Changing the other bits while bit 7 stays high has no effect.
- R3: A strobed byte with bit 6 set makes register cfg_byte[5:0] the current register. From the next cycle, rd_value shows that register's contents.
- R4: A strobed byte with bit 6 clear, coming after an address byte, writes cfg_byte[5:0] into the current register. The write is seen on rd_value from the next cycle.
- R5: A strobed value byte with no address byte since the last write, or since reset, changes no register.
- R6: rd_value[6] is always 0, and rd_value[5:0] equals the current register.
- R7: A write to register 3 stores the source {reg2, written value} in the entry for destination {reg0, reg1}. route_src shows the new source from the next cycle.
- R8: A routing update changes only the addressed destination. The same source may be stored for several destinations.
- R9: A destination index of DST_COUNT or more changes no entry. route_src reads 0 for such a select.
- R10: Writing a new source for a destination that is already routed replaces its old source.
- R11: Writes to registers 0, 1 and 2 do not change the routing table.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_byte | input | 8 | Host byte: bit 7 strobe, bit 6 address flag, bits 5:0 register number or value |
| route_sel | input | 12 | Destination index whose routing entry is read |
| rd_value | output | 7 | Contents of the current register, bit 6 zero |
| route_src | output | 12 | Source stored for route_sel, or 0 if route_sel is out of range |

## Verification
The bench holds the strobe high and changes the value bits underneath it. A design that detects levels instead of edges would write the second value.

It sends a value byte right after a completed write. A design that keeps the address armed would overwrite the register.

It writes registers 0 to 2 and then reads the table before register 3 is written. A design that updates the table on any command register would show the new link too early.

It also routes one source to several destinations, re-routes a destination, and sends a destination index above the table size. These catch a design that clears other entries, keeps the old link, or wraps the index into the table.

// File: rtl/cfg_route_pkg.sv
// Package: constants shared by the configuration port blocks.
// Assumes a byte layout of strobe in bit 7 and address flag in bit 6.
package cfg_route_pkg;
    localparam int STROBE_BIT   = 7;
    localparam int ADDR_FLAG    = 6;
    // Command registers that make up one routing link
    localparam int CMD_DST_HI   = 0;
    localparam int CMD_DST_LO   = 1;
    localparam int CMD_SRC_HI   = 2;
    localparam int CMD_SRC_LO   = 3;
endpackage

// File: rtl/cfg_strobe_decode.sv
// Module: detects the rising edge of the strobe bit and sorts the byte
// into an address strobe or a value strobe.
// Assumes cfg byte is synchronous to clk.
module cfg_strobe_decode #(
    parameter int FIELD_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [7:0]         byte_in,
    output logic               stb_addr,
    output logic               stb_val,
    output logic [FIELD_W-1:0] field
);
    import cfg_route_pkg::*;

    logic strobe_q;
    logic strobe_edge;

    // Remember last strobe level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= byte_in[STROBE_BIT];
    end

    // Classify the byte on the strobe rising edge
    always_comb begin
        strobe_edge = byte_in[STROBE_BIT] & ~strobe_q;
        stb_addr    = strobe_edge &  byte_in[ADDR_FLAG];
        stb_val     = strobe_edge & ~byte_in[ADDR_FLAG];
        field       = byte_in[FIELD_W-1:0];
    end
endmodule

// File: rtl/cfg_regfile.sv
// Module: register file with an address pointer that is armed by an
// address strobe and consumed by one value strobe. Produces the
// routing update request when the low source register is written.
// Assumes register number width does not exceed FIELD_W.
module cfg_regfile #(
    parameter int NUM_REGS = 64,
    parameter int FIELD_W  = 6,
    localparam int AW      = $clog2(NUM_REGS),
    localparam int IDX_W   = 2 * FIELD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stb_addr,
    input  logic               stb_val,
    input  logic [FIELD_W-1:0] field,
    output logic               wr_en,
    output logic [AW-1:0]      wr_addr,
    output logic [FIELD_W-1:0] rd_field,
    output logic               upd_en,
    output logic [IDX_W-1:0]   upd_dst,
    output logic [IDX_W-1:0]   upd_src
);
    import cfg_route_pkg::*;

    logic [FIELD_W-1:0] regs [NUM_REGS];
    logic [AW-1:0]      ptr;
    logic               armed;

    // Pointer, arm flag and register storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr   <= '0;
            armed <= 1'b0;
            for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
        end else if (stb_addr) begin
            ptr   <= field[AW-1:0];
            armed <= 1'b1;
        end else if (wr_en) begin
            regs[ptr] <= field;
            armed     <= 1'b0;
        end
    end

    // Write qualification, readback and routing request
    always_comb begin
        wr_en    = stb_val & armed;
        wr_addr  = ptr;
        rd_field = regs[ptr];
        upd_en   = wr_en && (ptr == AW'(CMD_SRC_LO));
        upd_dst  = {regs[CMD_DST_HI], regs[CMD_DST_LO]};
        upd_src  = {regs[CMD_SRC_HI], field};
    end
endmodule

// File: rtl/cfg_route_table.sv
// Module: one source entry per destination, written by the update
// request and read through a select input.
// Assumes DST_COUNT fits in the destination index width.
module cfg_route_table #(
    parameter int DST_COUNT = 32,
    parameter int IDX_W     = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_dst,
    input  logic [IDX_W-1:0] upd_src,
    input  logic [IDX_W-1:0] sel,
    output logic [IDX_W-1:0] sel_src
);
    logic [IDX_W-1:0] tbl [DST_COUNT];

    for (genvar e = 0; e < DST_COUNT; e++) begin : g_entry
        // Store the source for destination e on a matching update
        always_ff @(posedge clk) begin
            if (!rst_n)                                    tbl[e] <= '0;
            else if (upd_en && upd_dst == IDX_W'(e))       tbl[e] <= upd_src;
        end
    end

    // Select one entry, zero when out of range
    always_comb begin
        sel_src = '0;
        for (int e = 0; e < DST_COUNT; e++)
            if (sel == IDX_W'(e)) sel_src = tbl[e];
    end
endmodule

// File: rtl/cfg_route_port.sv
// Module: top of the strobed byte configuration port with routing table.
// Assumes host bytes arrive synchronous to clk, strobe low between bytes.
module cfg_route_port #(
    parameter int NUM_REGS  = 64,
    parameter int FIELD_W   = 6,
    parameter int DST_COUNT = 32,
    localparam int AW       = $clog2(NUM_REGS),
    localparam int IDX_W    = 2 * FIELD_W,
    localparam int RD_W     = FIELD_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       cfg_byte,
    input  logic [IDX_W-1:0] route_sel,
    output logic [RD_W-1:0]  rd_value,
    output logic [IDX_W-1:0] route_src
);
    logic               stb_addr, stb_val, wr_en, upd_en;
    logic [FIELD_W-1:0] field, rd_field;
    logic [AW-1:0]      wr_addr;
    logic [IDX_W-1:0]   upd_dst, upd_src;

    cfg_strobe_decode #(.FIELD_W(FIELD_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .byte_in(cfg_byte),
        .stb_addr(stb_addr), .stb_val(stb_val), .field(field)
    );

    cfg_regfile #(.NUM_REGS(NUM_REGS), .FIELD_W(FIELD_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .stb_addr(stb_addr), .stb_val(stb_val),
        .field(field), .wr_en(wr_en), .wr_addr(wr_addr), .rd_field(rd_field),
        .upd_en(upd_en), .upd_dst(upd_dst), .upd_src(upd_src)
    );

    cfg_route_table #(.DST_COUNT(DST_COUNT), .IDX_W(IDX_W)) u_route (
        .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .upd_dst(upd_dst),
        .upd_src(upd_src), .sel(route_sel), .sel_src(route_src)
    );

    // Readback is the current register, zero-extended
    assign rd_value = {1'b0, rd_field};
endmodule

// File: rtl/cfg_route_port_chk.sv
// Module: assertion checker attached to the configuration port top.
module cfg_route_port_chk #(
    parameter int AW   = 6,
    parameter int RD_W = 7
) (
    input logic            clk,
    input logic            rst_n,
    input logic [RD_W-1:0] rd_value,
    input logic            stb_addr,
    input logic            stb_val,
    input logic            wr_en,
    input logic [AW-1:0]   wr_addr,
    input logic            upd_en
);
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> rd_value == '0);

    assert_one_strobe_per_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_addr || stb_val) |=> !(stb_addr || stb_val));

    assert_write_needs_value_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> stb_val);

    assert_top_bit_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_value[RD_W-1] == 1'b0);

    assert_update_on_low_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |-> (wr_en && wr_addr == AW'(3)));
endmodule

bind cfg_route_port cfg_route_port_chk #(.AW(AW), .RD_W(RD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_value(rd_value), .stb_addr(stb_addr),
    .stb_val(stb_val), .wr_en(wr_en), .wr_addr(wr_addr), .upd_en(upd_en)
);

// File: tb/cfg_route_port_tb.sv
module cfg_route_port_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_byte = 8'h00;
    logic [11:0] route_sel = 12'h000;
    logic [6:0]  rd_value;
    logic [11:0] route_src;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    typedef struct {
        bit          is_route;
        logic [11:0] sel;
        logic [11:0] expv;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #5 clk = ~clk;

    cfg_route_port u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_byte(cfg_byte),
        .route_sel(route_sel), .rd_value(rd_value), .route_src(route_src)
    );

    // Monitor: pop one expected item per falling edge and compare
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            logic [11:0] act;
            it = sb_q.pop_front();
            act = it.is_route ? route_src : {5'b0, rd_value};
            checks++;
            if (act !== it.expv) begin
                errors++;
                $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.expv);
            end
        end
    end

    task automatic push_chk(bit is_route, logic [11:0] sel, logic [11:0] expv, string tag);
        item_t it;
        #1;
        route_sel = sel;
        it.is_route = is_route; it.sel = sel; it.expv = expv; it.tag = tag;
        sb_q.push_back(it);
        while (sb_q.size() != 0) @(negedge clk);
    endtask

    task automatic send_byte(logic [7:0] b);
        @(negedge clk) cfg_byte = b & 8'h7F;
        @(negedge clk) cfg_byte = b | 8'h80;
        @(negedge clk) cfg_byte = b & 8'h7F;
    endtask

    task automatic wr_reg(logic [5:0] a, logic [5:0] v);
        send_byte(8'h40 | {2'b0, a});
        send_byte({2'b0, v});
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0; cfg_byte = 8'h00;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        // R1: reset state
        push_chk(0, 12'h000, 12'h000, "R1 rd_value after reset");
        push_chk(1, 12'd5,   12'h000, "R1 route 5 after reset");
        push_chk(1, 12'd31,  12'h000, "R1 route 31 after reset");

        // R3 R4: write then read back
        wr_reg(6'd10, 6'h2A);
        send_byte(8'h4A);
        push_chk(0, 12'h000, 12'h02A, "R4 reg10 written");
        wr_reg(6'd11, 6'h07);
        send_byte(8'h4A);
        push_chk(0, 12'h000, 12'h02A, "R3 reselect reg10");
        send_byte(8'h4B);
        push_chk(0, 12'h000, 12'h007, "R3 select reg11");

        // R5: value with no armed address
        send_byte(8'h4A);
        send_byte(8'h11);
        send_byte(8'h22);
        push_chk(0, 12'h000, 12'h011, "R5 second value ignored");

        // R2: change bits under a held strobe
        send_byte(8'h4A);
        @(negedge clk) cfg_byte = 8'h15;
        @(negedge clk) cfg_byte = 8'h95;
        @(negedge clk) cfg_byte = 8'h96;
        @(negedge clk) cfg_byte = 8'h16;
        push_chk(0, 12'h000, 12'h015, "R2 held strobe no rewrite");

        // R6: full-scale value keeps bit 6 clear
        wr_reg(6'd20, 6'h3F);
        push_chk(0, 12'h000, 12'h03F, "R6 full value, top bit zero");

        // R7: first link dst 5 <- src 0x042
        wr_reg(6'd0, 6'h00);
        wr_reg(6'd1, 6'h05);
        wr_reg(6'd2, 6'h01);
        wr_reg(6'd3, 6'h02);
        push_chk(1, 12'd5, 12'h042, "R7 link dst5");

        // R11: command regs 0..2 alone do not update
        wr_reg(6'd1, 6'h07);
        wr_reg(6'd2, 6'h03);
        push_chk(1, 12'd7, 12'h000, "R11 no update before reg3");
        wr_reg(6'd3, 6'h04);
        push_chk(1, 12'd7, 12'h0C4, "R7 link dst7");
        push_chk(1, 12'd5, 12'h042, "R8 dst5 untouched");

        // R8: same source to another destination
        wr_reg(6'd1, 6'h09);
        wr_reg(6'd3, 6'h04);
        push_chk(1, 12'd9, 12'h0C4, "R8 dst9 shares source");
        push_chk(1, 12'd7, 12'h0C4, "R8 dst7 kept");

        // R10: replace existing link
        wr_reg(6'd1, 6'h05);
        wr_reg(6'd3, 6'h3F);
        push_chk(1, 12'd5, 12'h0FF, "R10 dst5 replaced");

        // R9: out-of-range destination 0x045
        wr_reg(6'd0, 6'h01);
        wr_reg(6'd3, 6'h01);
        push_chk(1, 12'd5,    12'h0FF, "R9 dst5 not aliased");
        push_chk(1, 12'h045,  12'h000, "R9 out of range reads zero");

        // R7: maximum source on the last entry
        wr_reg(6'd0, 6'h00);
        wr_reg(6'd1, 6'h1F);
        wr_reg(6'd2, 6'h3F);
        wr_reg(6'd3, 6'h3F);
        push_chk(1, 12'd31, 12'hFFF, "R7 dst31 max source");

        // R1: reset clears everything again
        send_byte(8'h54);
        do_reset();
        push_chk(0, 12'h000, 12'h000, "R1 rd_value after second reset");
        push_chk(1, 12'd31,  12'h000, "R1 route 31 cleared");
        push_chk(1, 12'd5,   12'h000, "R1 route 5 cleared");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule